// File: doc/BRIEF.md
# Address translation permission checker

This block takes one memory access (virtual address, access kind, privilege level and translation mode) together with the candidate page entries returned by a set of parallel TLB lookups. It produces either a physical address, a fault code, or a request to start a page-table walk. Up to five lookup sources can hit at the same time: a third-level array, two superpage arrays and two ordinary arrays. A fixed priority picks one of them. The chosen entry then goes through the usual page permission rules and a dirty-bit rule for stores. The result is formed from the page number and the page-size offset.

Machine privilege, or a bare translation mode, skips the lookup entirely and passes the address through. Every physical address with its top bit set is refused with an access fault that matches the access kind. The decision is combinational. It is captured in an output register behind a valid/ready handshake, so the caller sees one result per accepted request, one cycle after acceptance.

Top module: `xlat_perm_chk`

## Requirements
- R1: When `in_priv` is 3 (machine) or `in_xmode` is 0 (bare), `out_paddr` equals `in_vaddr`. In that case the hit vector and entries are ignored and `out_walk` stays 0.
- R2: A physical address with bit 63 set gives fault code 1 for a read (`in_acc`=0), 2 for a write (`in_acc`=1) and 3 for a fetch (`in_acc`=2).
- R3: Among the set bits of `in_hit`, the highest index wins. Bit 4 is the level-3 array, bit 3 the level-2 superpage array, bit 2 the level-1 superpage array, bit 1 the level-2 array and bit 0 the level-1 array. Source s uses slice s of each entry bus.
- R4: In translated mode with `in_hit` all zero, the result has `out_walk`=1, fault code 0 and `out_paddr`=0.
- R5: The translated address is (PPN << 12) OR (vaddr AND mask). The mask has 12 low bits for size code 0, 21 for code 1 and 30 for code 2. Code 3 is treated as code 0.
- R6: A write to an entry whose dirty bit is clear raises store page fault (code 5). A page fault takes precedence over the bit-63 access fault.
- R7: The permission field is bit0 R, bit1 W, bit2 X, bit3 U, bit4 D. A read needs R, or X together with `in_mxr`. A write needs W. A fetch needs X. A refusal gives code 4 for a read, 5 for a write and 6 for a fetch.
- R8: User privilege (`in_priv`=0) needs U set. Supervisor privilege (`in_priv`=1) on a U page needs `in_sum` and is always refused for fetches. A refusal uses the codes of R7.
- R9: `in_ready` is high when the output register is empty or being drained. A result appears on the outputs one cycle after acceptance and stays stable while `out_valid` is high and `out_ready` is low.
- R10: During and after reset, `out_valid` is 0 and `in_ready` is 1. `out_paddr` is 0 whenever the fault code is non-zero or `out_walk` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_vaddr | input | 64 | Virtual address |
| in_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| in_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| in_xmode | input | 4 | Translation mode, 0 = bare |
| in_sum | input | 1 | Supervisor may touch user pages |
| in_mxr | input | 1 | Executable pages readable |
| in_hit | input | NSRC | Lookup hit vector, one bit per source |
| in_ppn | input | NSRC*PPN_W | Page numbers, one slice per source |
| in_pgsz | input | NSRC*2 | Page size codes, one slice per source |
| in_perm | input | NSRC*5 | Permission fields, one slice per source |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this cycle |
| out_paddr | output | 64 | Physical address |
| out_fault | output | 3 | Fault code, 0 = none |
| out_walk | output | 1 | Page-table walk needed |

## Verification
If the priority selection goes wrong, the wrong source's page number shows up in `out_paddr` on the cycle after acceptance. The bench gives each source a distinct page number, so a source swap is visible at once. A wrong permission or dirty decision shows up at the same moment as a fault code differing from the one the rules predict. A bypass or top-bit error shows as an address or code mismatch on that same response. A handshake fault shows as a result that changes or disappears while the consumer stalls.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int PG_SHIFT = 12;
  localparam int LVL_BITS = 9;
  localparam int PA_W     = 64;
  localparam int PERM_W   = 5;
  localparam int SZ_W     = 2;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam logic [2:0] FLT_NONE   = 3'd0;
  localparam logic [2:0] FLT_LD_ACC = 3'd1;
  localparam logic [2:0] FLT_ST_ACC = 3'd2;
  localparam logic [2:0] FLT_IF_ACC = 3'd3;
  localparam logic [2:0] FLT_LD_PG  = 3'd4;
  localparam logic [2:0] FLT_ST_PG  = 3'd5;
  localparam logic [2:0] FLT_IF_PG  = 3'd6;

  typedef struct packed {
    logic d;
    logic u;
    logic x;
    logic w;
    logic r;
  } perm_t;

  // number of address bits kept from the virtual address for a size code
  function automatic int unsigned off_bits(input logic [SZ_W-1:0] sz);
    case (sz)
      2'd1:    off_bits = PG_SHIFT + LVL_BITS;
      2'd2:    off_bits = PG_SHIFT + 2 * LVL_BITS;
      default: off_bits = PG_SHIFT;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] off_mask(input logic [SZ_W-1:0] sz);
    off_mask = (PA_W'(1) << off_bits(sz)) - PA_W'(1);
  endfunction

  function automatic logic [PA_W-1:0] form_pa(input logic [PA_W-1:0] base,
                                               input logic [PA_W-1:0] va,
                                               input logic [SZ_W-1:0] sz);
    form_pa = base | (va & off_mask(sz));
  endfunction

  function automatic logic [2:0] acc_fault_code(input logic [1:0] acc);
    case (acc)
      ACC_RD:  acc_fault_code = FLT_LD_ACC;
      ACC_WR:  acc_fault_code = FLT_ST_ACC;
      default: acc_fault_code = FLT_IF_ACC;
    endcase
  endfunction

  function automatic logic [2:0] pg_fault_code(input logic [1:0] acc);
    case (acc)
      ACC_RD:  pg_fault_code = FLT_LD_PG;
      ACC_WR:  pg_fault_code = FLT_ST_PG;
      default: pg_fault_code = FLT_IF_PG;
    endcase
  endfunction

endpackage

// File: rtl/xlat_hit_pick.sv
module xlat_hit_pick #(
  parameter  int NSRC  = 5,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  hit_vec,
  output logic [NSRC-1:0]  pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_any
);

  // highest index has highest priority
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_pri
      if (gi == NSRC - 1) begin : g_top
        assign pick_oh[gi] = hit_vec[gi];
      end else begin : g_low
        assign pick_oh[gi] = hit_vec[gi] & ~(|hit_vec[NSRC-1:gi+1]);
      end
    end
  endgenerate

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pick_oh[i]) pick_idx = IDX_W'(i);
    end
  end

  assign pick_any = |hit_vec;

endmodule

// File: rtl/xlat_entry_mux.sv
module xlat_entry_mux
  import xlat_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int PPN_W = 52
) (
  input  logic [NSRC-1:0]        pick_oh,
  input  logic [NSRC*PPN_W-1:0]  ppn_flat,
  input  logic [NSRC*SZ_W-1:0]   sz_flat,
  input  logic [NSRC*PERM_W-1:0] perm_flat,
  output logic [PPN_W-1:0]       sel_ppn,
  output logic [SZ_W-1:0]        sel_sz,
  output perm_t                  sel_perm
);

  logic [NSRC*PPN_W-1:0]  ppn_gated;
  logic [NSRC*SZ_W-1:0]   sz_gated;
  logic [NSRC*PERM_W-1:0] perm_gated;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_gate
      assign ppn_gated[gi*PPN_W +: PPN_W]   = {PPN_W{pick_oh[gi]}}  & ppn_flat[gi*PPN_W +: PPN_W];
      assign sz_gated[gi*SZ_W +: SZ_W]      = {SZ_W{pick_oh[gi]}}   & sz_flat[gi*SZ_W +: SZ_W];
      assign perm_gated[gi*PERM_W +: PERM_W] = {PERM_W{pick_oh[gi]}} & perm_flat[gi*PERM_W +: PERM_W];
    end
  endgenerate

  always_comb begin
    logic [PERM_W-1:0] perm_acc;
    sel_ppn  = '0;
    sel_sz   = '0;
    perm_acc = '0;
    for (int i = 0; i < NSRC; i++) begin
      sel_ppn  = sel_ppn  | ppn_gated[i*PPN_W +: PPN_W];
      sel_sz   = sel_sz   | sz_gated[i*SZ_W +: SZ_W];
      perm_acc = perm_acc | perm_gated[i*PERM_W +: PERM_W];
    end
    sel_perm = perm_t'(perm_acc);
  end

endmodule

// File: rtl/xlat_rights.sv
module xlat_rights
  import xlat_pkg::*;
(
  input  logic [1:0] acc,
  input  logic [1:0] priv,
  input  logic       sum,
  input  logic       mxr,
  input  perm_t      perm,
  output logic       deny
);

  logic kind_ok;
  logic mode_ok;

  always_comb begin
    case (acc)
      ACC_RD:  kind_ok = perm.r | (perm.x & mxr);
      ACC_WR:  kind_ok = perm.w & perm.d;
      ACC_FX:  kind_ok = perm.x;
      default: kind_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (priv)
      PRV_U:   mode_ok = perm.u;
      PRV_S:   mode_ok = ~perm.u | (sum & (acc != ACC_FX));
      default: mode_ok = 1'b1;
    endcase
  end

  assign deny = ~(kind_ok & mode_ok);

endmodule

// File: rtl/xlat_perm_chk.sv
module xlat_perm_chk
  import xlat_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int PPN_W = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PA_W-1:0]         in_vaddr,
  input  logic [1:0]              in_acc,
  input  logic [1:0]              in_priv,
  input  logic [3:0]              in_xmode,
  input  logic                    in_sum,
  input  logic                    in_mxr,
  input  logic [NSRC-1:0]         in_hit,
  input  logic [NSRC*PPN_W-1:0]   in_ppn,
  input  logic [NSRC*SZ_W-1:0]    in_pgsz,
  input  logic [NSRC*PERM_W-1:0]  in_perm,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [PA_W-1:0]         out_paddr,
  output logic [2:0]              out_fault,
  output logic                    out_walk
);

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  // named internal events
  logic [NSRC-1:0]  pick_oh;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;
  logic [PPN_W-1:0] sel_ppn;
  logic [SZ_W-1:0]  sel_sz;
  perm_t            sel_perm;
  logic             bypass;
  logic             pg_deny;
  logic             walk_req;
  logic             pg_flt;
  logic             top_bit;
  logic             acc_flt;
  logic             accept;
  logic [PA_W-1:0]  xl_pa;
  logic [PA_W-1:0]  raw_pa;
  logic [PA_W-1:0]  nxt_pa;
  logic [2:0]       nxt_fault;

  xlat_hit_pick #(.NSRC(NSRC)) u_pick (
    .hit_vec  (in_hit),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .pick_any (pick_any)
  );

  xlat_entry_mux #(.NSRC(NSRC), .PPN_W(PPN_W)) u_mux (
    .pick_oh   (pick_oh),
    .ppn_flat  (in_ppn),
    .sz_flat   (in_pgsz),
    .perm_flat (in_perm),
    .sel_ppn   (sel_ppn),
    .sel_sz    (sel_sz),
    .sel_perm  (sel_perm)
  );

  xlat_rights u_rights (
    .acc  (in_acc),
    .priv (in_priv),
    .sum  (in_sum),
    .mxr  (in_mxr),
    .perm (sel_perm),
    .deny (pg_deny)
  );

  assign bypass   = (in_priv == PRV_M) | (in_xmode == 4'd0);
  assign xl_pa    = form_pa(PA_W'(sel_ppn) << PG_SHIFT, in_vaddr, sel_sz);
  assign raw_pa   = bypass ? in_vaddr : xl_pa;
  assign walk_req = ~bypass & ~pick_any;
  assign pg_flt   = ~bypass & pick_any & pg_deny;
  assign top_bit  = raw_pa[PA_W-1];
  assign acc_flt  = ~walk_req & ~pg_flt & top_bit;

  always_comb begin
    if (pg_flt)       nxt_fault = pg_fault_code(in_acc);
    else if (acc_flt) nxt_fault = acc_fault_code(in_acc);
    else              nxt_fault = FLT_NONE;
  end

  assign nxt_pa   = (walk_req | pg_flt | acc_flt) ? '0 : raw_pa;
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_fault <= FLT_NONE;
      out_walk  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_paddr <= nxt_pa;
      out_fault <= nxt_fault;
      out_walk  <= walk_req;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/xlat_perm_chk_props.sv
module xlat_perm_chk_props #(
  parameter int NSRC = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [63:0]     in_vaddr,
  input logic [1:0]      in_acc,
  input logic [NSRC-1:0] in_hit,
  input logic            out_valid,
  input logic            out_ready,
  input logic [63:0]     out_paddr,
  input logic [2:0]      out_fault,
  input logic            out_walk,
  input logic [NSRC-1:0] pick_oh,
  input logic [4:0]      sel_perm,
  input logic            bypass,
  input logic            pick_any
);

  logic take;
  assign take = in_valid & in_ready;

  // R9: held result does not move while stalled
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_paddr) && $stable(out_fault) && $stable(out_walk));

  // R9: an accepted request yields a result on the next cycle
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R3: selection is a single hitting source
  assert_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh) && ((pick_oh & ~in_hit) == '0) && (pick_any == (pick_oh != '0)));

  // R1: bypass passes the address through
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && bypass && !in_vaddr[63] |=> out_paddr == $past(in_vaddr) && out_fault == 3'd0 && !out_walk);

  // R2: top bit set under bypass always faults
  assert_topbit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && bypass && in_vaddr[63] |=> out_fault != 3'd0 && out_paddr == 64'd0);

  // R4 / R10: a walk carries no fault and no address
  assert_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_walk |-> out_fault == 3'd0 && out_paddr == 64'd0);

  // R6: store to clean page is a store page fault
  assert_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bypass && pick_any && in_acc == 2'd1 && !sel_perm[4] |=> out_fault == 3'd5);

endmodule

bind xlat_perm_chk xlat_perm_chk_props #(.NSRC(NSRC)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_vaddr  (in_vaddr),
  .in_acc    (in_acc),
  .in_hit    (in_hit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_paddr (out_paddr),
  .out_fault (out_fault),
  .out_walk  (out_walk),
  .pick_oh   (pick_oh),
  .sel_perm  (sel_perm),
  .bypass    (bypass),
  .pick_any  (pick_any)
);

// File: tb/xlat_perm_chk_tb.sv
module xlat_perm_chk_tb_top;

  localparam int NSRC  = 5;
  localparam int PPN_W = 52;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [63:0]           in_vaddr = '0;
  logic [1:0]            in_acc = '0;
  logic [1:0]            in_priv = '0;
  logic [3:0]            in_xmode = '0;
  logic                  in_sum = 1'b0;
  logic                  in_mxr = 1'b0;
  logic [NSRC-1:0]       in_hit = '0;
  logic [NSRC*PPN_W-1:0] in_ppn = '0;
  logic [NSRC*2-1:0]     in_pgsz = '0;
  logic [NSRC*5-1:0]     in_perm = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b1;
  logic [63:0]           out_paddr;
  logic [2:0]            out_fault;
  logic                  out_walk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xlat_perm_chk #(.NSRC(NSRC), .PPN_W(PPN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vaddr(in_vaddr), .in_acc(in_acc), .in_priv(in_priv), .in_xmode(in_xmode),
    .in_sum(in_sum), .in_mxr(in_mxr), .in_hit(in_hit), .in_ppn(in_ppn),
    .in_pgsz(in_pgsz), .in_perm(in_perm), .out_valid(out_valid),
    .out_ready(out_ready), .out_paddr(out_paddr), .out_fault(out_fault),
    .out_walk(out_walk)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [63:0] va;
    logic [1:0]  acc;
    logic [1:0]  priv;
    logic [3:0]  xm;
    logic        sum;
    logic        mxr;
    logic        hi;
    logic [4:0]  hit;
    logic [4:0]  perm;
    logic [1:0]  sz;
    logic [2:0]  ef;
    logic        ew;
    logic [2:0]  esrc;
  } vec_t;

  localparam logic [63:0] VA1  = 64'h0000_0000_1234_5678;
  localparam logic [63:0] VTOP = 64'h8000_0000_0000_0010;

  localparam vec_t VT [22] = '{
    '{4'd5, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00001, 5'b00001, 2'd0, 3'd0, 1'b0, 3'd0}, // R5 4K
    '{4'd3, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b11111, 5'b00001, 2'd0, 3'd0, 1'b0, 3'd4}, // R3 all hit
    '{4'd3, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00110, 5'b00001, 2'd1, 3'd0, 1'b0, 3'd2}, // R3 R5 2M
    '{4'd5, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b01010, 5'b00001, 2'd2, 3'd0, 1'b0, 3'd3}, // R5 1G
    '{4'd4, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00001, 2'd0, 3'd0, 1'b1, 3'd0}, // R4 miss
    '{4'd6, VA1,  2'd1, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00001, 5'b00011, 2'd0, 3'd5, 1'b0, 3'd0}, // R6 clean
    '{4'd6, VA1,  2'd1, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00100, 5'b10011, 2'd0, 3'd0, 1'b0, 3'd2}, // R6 dirty ok
    '{4'd7, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00001, 5'b00100, 2'd0, 3'd4, 1'b0, 3'd0}, // R7 x no mxr
    '{4'd7, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b1, 1'b0, 5'b00001, 5'b00100, 2'd0, 3'd0, 1'b0, 3'd0}, // R7 mxr
    '{4'd8, VA1,  2'd2, 2'd1, 4'h8, 1'b1, 1'b0, 1'b0, 5'b00001, 5'b01100, 2'd0, 3'd6, 1'b0, 3'd0}, // R8 S fetch U
    '{4'd8, VA1,  2'd0, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00010, 5'b01001, 2'd0, 3'd4, 1'b0, 3'd1}, // R8 no sum
    '{4'd8, VA1,  2'd0, 2'd1, 4'h8, 1'b1, 1'b0, 1'b0, 5'b00010, 5'b01001, 2'd0, 3'd0, 1'b0, 3'd1}, // R8 sum
    '{4'd8, VA1,  2'd0, 2'd0, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00001, 5'b00001, 2'd0, 3'd4, 1'b0, 3'd0}, // R8 U on S page
    '{4'd8, VA1,  2'd0, 2'd0, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00001, 5'b01001, 2'd0, 3'd0, 1'b0, 3'd0}, // R8 U ok
    '{4'd2, VTOP, 2'd0, 2'd1, 4'h0, 1'b0, 1'b0, 1'b0, 5'b11111, 5'b00000, 2'd0, 3'd1, 1'b0, 3'd0}, // R2 bare read
    '{4'd2, VTOP, 2'd1, 2'd3, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 2'd0, 3'd2, 1'b0, 3'd0}, // R2 M write
    '{4'd1, 64'h1234, 2'd2, 2'd3, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 2'd0, 3'd0, 1'b0, 3'd0}, // R1 M no walk
    '{4'd2, VTOP, 2'd2, 2'd3, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 2'd0, 3'd3, 1'b0, 3'd0}, // R2 M fetch
    '{4'd2, VA1,  2'd2, 2'd1, 4'h8, 1'b0, 1'b0, 1'b1, 5'b00001, 5'b00100, 2'd0, 3'd3, 1'b0, 3'd0}, // R2 translated
    '{4'd6, VA1,  2'd1, 2'd1, 4'h8, 1'b0, 1'b0, 1'b1, 5'b00001, 5'b00011, 2'd0, 3'd5, 1'b0, 3'd0}, // R6 precedence
    '{4'd5, VA1,  2'd1, 2'd0, 4'h8, 1'b0, 1'b0, 1'b0, 5'b01000, 5'b11010, 2'd3, 3'd0, 1'b0, 3'd3}, // R5 code 3
    '{4'd7, VA1,  2'd1, 2'd1, 4'h8, 1'b0, 1'b0, 1'b0, 5'b00001, 5'b10001, 2'd0, 3'd5, 1'b0, 3'd0}  // R7 no W
  };

  function automatic logic [51:0] ppn_of(input int s, input logic hi);
    ppn_of = 52'h80000 + 52'(s + 1) * 52'h1000 + (hi ? 52'h8_0000_0000_0000 : 52'h0);
  endfunction

  function automatic logic [63:0] exp_pa(input vec_t v);
    int unsigned ob;
    ob = (v.sz == 2'd1) ? 21 : (v.sz == 2'd2) ? 30 : 12;
    if (v.ef != 3'd0 || v.ew) return 64'd0;
    if (v.priv == 2'd3 || v.xm == 4'h0) return v.va;
    return 64'(ppn_of(int'(v.esrc), v.hi)) * 64'd4096 + (v.va % (64'd1 << ob));
  endfunction

  task automatic drive(input vec_t v);
    in_vaddr = v.va; in_acc = v.acc; in_priv = v.priv; in_xmode = v.xm;
    in_sum = v.sum; in_mxr = v.mxr; in_hit = v.hit;
    for (int s = 0; s < NSRC; s++) begin
      in_ppn[s*PPN_W +: PPN_W] = ppn_of(s, v.hi);
      in_pgsz[s*2 +: 2] = v.sz;
      in_perm[s*5 +: 5] = v.perm;
    end
    in_valid = 1'b1;
  endtask

  task automatic check_out(input logic [63:0] epa, input logic [2:0] ef, input logic ew,
                           input string tag);
    n_cmp++;
    if (out_valid !== 1'b1 || out_paddr !== epa || out_fault !== ef || out_walk !== ew) begin
      n_bad++;
      $display("FAIL %s: got v=%b pa=%h f=%0d w=%b, expected v=1 pa=%h f=%0d w=%b",
               tag, out_valid, out_paddr, out_fault, out_walk, epa, ef, ew);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check_bit(out_valid, 1'b0, "R10 out_valid in reset");
    check_bit(in_ready, 1'b1, "R10 in_ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R10 out_valid after reset");

    // table walk
    for (int k = 0; k < 22; k++) begin
      drive(VT[k]);
      @(negedge clk);
      in_valid = 1'b0;
      check_out(exp_pa(VT[k]), VT[k].ef, VT[k].ew, $sformatf("R%0d vector %0d", VT[k].rq, k));
    end

    // R9: backpressure holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    drive(VT[0]);
    @(negedge clk);
    check_bit(in_ready, 1'b0, "R9 in_ready while stalled");
    drive(VT[1]);
    repeat (2) @(negedge clk);
    check_out(exp_pa(VT[0]), VT[0].ef, VT[0].ew, "R9 held result");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(exp_pa(VT[1]), VT[1].ef, VT[1].ew, "R9 result after release R3");
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R9 drained");

    finish_run();
  end

endmodule